// File: doc/BRIEF.md
# Redundant Reference Switchover Controller

This block chooses which of two reference clocks feeds a phase-locked loop. It runs in the phase-detector clock domain. Its inputs are a qualification flag for each reference, which a separate qualifier produces, a user select pin, a manual/automatic mode pin and a bypass pin. Its outputs are the active-reference select, an active-low busy flag and a holdover flag that tells the loop to freeze its control voltage.

In automatic mode the controller may override the user select. When the active reference loses qualification and the other one is qualified, it moves to the other one. It then stays there even after the original reference recovers. A fresh, debounced edge on the user select re-arms the choice. When neither reference qualifies, the controller enters holdover. In manual mode, or while bypassed, the select simply follows the user pin. Every switch opens a phase-realignment window of a programmable number of cycles, during which busy is low.

Top module: `refsw_ctrl`

## Requirements
- R1: After reset ends, the active select settles to the level of the user select pin, with busy high and no holdover.
- R2: In automatic mode, when the active reference is unqualified and the other is qualified (bit i of `ref_ok` high means reference i qualifies), the select moves to the other reference on the next clock edge.
- R3: After an automatic switch the select stays on the new reference while it qualifies, even when the former reference qualifies again.
- R4: In automatic mode a debounced change of the user select requests a switch. The switch is taken only if the requested reference differs from the active one and qualifies.
- R5: A user select level must hold for 2 consecutive samples (parameter `SEL_STABLE`) before it counts. A one-cycle pulse has no effect. A recognised change takes effect 3 clock edges after it is applied.
- R6: Busy goes low on the edge where a switch starts and stays low for exactly `ALIGN_CYC` cycles, then returns high.
- R7: In automatic mode, when no reference qualifies, the controller enters holdover on the next edge. In holdover, select reads 0, busy reads 1 and hold reads 1.
- R8: Leaving holdover in automatic mode, the controller takes the user-selected reference if both references qualify in the same cycle. If only one qualifies, it takes that one.
- R9: In manual mode or with bypass high, the select follows the debounced user select whatever the qualification flags say, and holdover is never entered.
- R10: While reset is asserted, select reads 0, busy reads 1 and hold reads 0.
- R11: Leaving holdover starts a realignment window, so busy is low for `ALIGN_CYC` cycles.
- R12: In automatic mode, if the target reference loses qualification while busy is low, the controller enters holdover on the next edge and busy returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_ok | input | 2 | Qualification flag per reference, bit i for reference i |
| usr_sel | input | 1 | User reference select |
| mode_manual | input | 1 | 1 = manual switching, 0 = automatic |
| bypass | input | 1 | Loop bypass; forces manual behaviour |
| act_sel | output | 1 | Active reference (reads 0 in holdover) |
| busy_n | output | 1 | Low during phase realignment after a switch |
| hold | output | 1 | Holdover active |

## Verification
Two functions can land on the same edge: a realignment window still running, and a loss of qualification on the reference being aligned to. The bench provokes this by dropping the new target's flag one cycle after a holdover exit has begun realignment. It expects holdover with busy high on the very next edge. On the following edge it expects a fresh switch to the surviving reference with busy low again. A second overlap, a user edge arriving while the flags also change, is judged by checking that the switch is taken only toward a qualified target.

// File: rtl/refsw_pkg.sv
package refsw_pkg;
  typedef enum logic [1:0] {
    ST_INIT  = 2'd0,
    ST_LOCK  = 2'd1,
    ST_ALIGN = 2'd2,
    ST_HOLD  = 2'd3
  } refsw_st_e;
endpackage

// File: rtl/refsw_rst_sync.sv
module refsw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/refsw_sel_filter.sv
module refsw_sel_filter #(
  parameter int SEL_STABLE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_raw,
  output logic sel_q,
  output logic sel_req,
  output logic sel_val,
  output logic primed
);
  localparam int PCW = $clog2(SEL_STABLE + 1);

  logic [SEL_STABLE-1:0] hist_q, hist_d;
  logic [PCW-1:0]        pcnt_q, pcnt_d;
  logic                  flt_q, flt_d;
  logic                  primed_q, primed_d;
  logic                  all_same, filled, prime_now, chg;

  generate
    if (SEL_STABLE == 1) begin : g_h1
      assign hist_d = sel_raw;
    end else begin : g_hn
      assign hist_d = {hist_q[SEL_STABLE-2:0], sel_raw};
    end
  endgenerate

  always_comb begin
    all_same  = (hist_q == {SEL_STABLE{hist_q[0]}});
    filled    = (pcnt_q == PCW'(SEL_STABLE));
    prime_now = !primed_q && filled && all_same;
    chg       = primed_q && all_same && (hist_q[0] != flt_q);
    pcnt_d    = filled ? pcnt_q : pcnt_q + PCW'(1);
    flt_d     = (prime_now || chg) ? hist_q[0] : flt_q;
    primed_d  = primed_q || prime_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q   <= '0;
      pcnt_q   <= '0;
      flt_q    <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      hist_q   <= hist_d;
      pcnt_q   <= pcnt_d;
      flt_q    <= flt_d;
      primed_q <= primed_d;
    end
  end

  assign sel_q   = flt_q;
  assign sel_req = chg;
  assign sel_val = hist_q[0];
  assign primed  = primed_q;
endmodule

// File: rtl/refsw_align_timer.sv
module refsw_align_timer #(
  parameter int ALIGN_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam int CW = (ALIGN_CYC > 1) ? $clog2(ALIGN_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(ALIGN_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    done   = (cnt_q == LAST);
    cnt_en = start || (run && !done);
    cnt_d  = start ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/refsw_fsm.sv
module refsw_fsm
  import refsw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ref_ok,
  input  logic       man,
  input  logic       sel_q,
  input  logic       sel_req,
  input  logic       sel_val,
  input  logic       primed,
  input  logic       done,
  output logic       start,
  output logic       act_sel,
  output logic       busy_n,
  output logic       hold,
  output logic       live
);
  refsw_st_e st_q, st_d;
  logic      act_q, act_d;
  logic      tgt, act_ok, oth_ok, req_ok;

  always_comb begin
    st_d   = st_q;
    act_d  = act_q;
    start  = 1'b0;
    tgt    = sel_req ? sel_val : sel_q;
    act_ok = ref_ok[act_q];
    oth_ok = ref_ok[!act_q];
    req_ok = sel_req && (sel_val != act_q) && ref_ok[sel_val];
    if (st_q == ST_INIT) begin
      if (primed) begin
        act_d = sel_q;
        st_d  = ST_LOCK;
      end
    end else if (man) begin
      if ((st_q == ST_HOLD) || (tgt != act_q)) begin
        act_d = tgt;
        st_d  = ST_ALIGN;
        start = 1'b1;
      end else if ((st_q == ST_ALIGN) && done) begin
        st_d = ST_LOCK;
      end
    end else if (st_q == ST_HOLD) begin
      if (ref_ok == 2'b11) begin
        act_d = tgt;
        st_d  = ST_ALIGN;
        start = 1'b1;
      end else if (ref_ok != 2'b00) begin
        act_d = ref_ok[1];
        st_d  = ST_ALIGN;
        start = 1'b1;
      end
    end else begin
      if (ref_ok == 2'b00) begin
        st_d = ST_HOLD;
      end else if ((st_q == ST_ALIGN) && !act_ok) begin
        st_d = ST_HOLD;
      end else if (req_ok) begin
        act_d = sel_val;
        st_d  = ST_ALIGN;
        start = 1'b1;
      end else if (!act_ok && oth_ok) begin
        act_d = !act_q;
        st_d  = ST_ALIGN;
        start = 1'b1;
      end else if ((st_q == ST_ALIGN) && done) begin
        st_d = ST_LOCK;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_INIT;
      act_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      act_q <= act_d;
    end
  end

  assign act_sel = (st_q == ST_HOLD) ? 1'b0 : act_q;
  assign busy_n  = (st_q != ST_ALIGN);
  assign hold    = (st_q == ST_HOLD);
  assign live    = (st_q != ST_INIT);
endmodule

// File: rtl/refsw_ctrl.sv
module refsw_ctrl #(
  parameter int ALIGN_CYC  = 64,
  parameter int SEL_STABLE = 2,
  parameter int RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ref_ok,
  input  logic       usr_sel,
  input  logic       mode_manual,
  input  logic       bypass,
  output logic       act_sel,
  output logic       busy_n,
  output logic       hold
);
  logic rst_n_s;
  logic man_w, live_w;
  logic sel_q, sel_req, sel_val, primed;
  logic tmr_start, tmr_done;

  assign man_w = mode_manual | bypass;

  refsw_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  refsw_sel_filter #(.SEL_STABLE(SEL_STABLE)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .sel_raw (usr_sel),
    .sel_q   (sel_q),
    .sel_req (sel_req),
    .sel_val (sel_val),
    .primed  (primed)
  );

  refsw_align_timer #(.ALIGN_CYC(ALIGN_CYC)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n_s),
    .start (tmr_start),
    .run   (!busy_n),
    .done  (tmr_done)
  );

  refsw_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .ref_ok  (ref_ok),
    .man     (man_w),
    .sel_q   (sel_q),
    .sel_req (sel_req),
    .sel_val (sel_val),
    .primed  (primed),
    .done    (tmr_done),
    .start   (tmr_start),
    .act_sel (act_sel),
    .busy_n  (busy_n),
    .hold    (hold),
    .live    (live_w)
  );
endmodule

// File: rtl/refsw_ctrl_chk.sv
module refsw_ctrl_chk #(
  parameter int ALIGN_CYC = 64
) (
  input logic       clk,
  input logic       rst_n_s,
  input logic [1:0] ref_ok,
  input logic       man,
  input logic       live,
  input logic       act_sel,
  input logic       busy_n,
  input logic       hold
);
  localparam int RW = $clog2(ALIGN_CYC + 2) + 1;
  localparam logic [RW-1:0] RMAX = {RW{1'b1}};

  logic [RW-1:0] run_q;
  logic          prev_act_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      run_q      <= '0;
      prev_act_q <= 1'b0;
    end else begin
      prev_act_q <= act_sel;
      if (busy_n)                   run_q <= '0;
      else if (act_sel != prev_act_q) run_q <= RW'(1);
      else if (run_q != RMAX)       run_q <= run_q + RW'(1);
    end
  end

  // R6: a realignment window never lasts longer than ALIGN_CYC cycles
  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    run_q <= RW'(ALIGN_CYC));

  // R2 and R4: an automatic-mode switch only lands on a qualified reference
  p_switch_valid_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!man && $past(!man) && live && $past(live) && !hold && !$past(hold)
     && (act_sel != $past(act_sel)))
    |-> (act_sel ? $past(ref_ok[1]) : $past(ref_ok[0])));

  // R7: no qualified reference in automatic mode leads to holdover
  p_hold_entry_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!man && live && !hold && (ref_ok == 2'b00)) |=> hold);

  // R9: manual or bypass never leaves the loop in holdover
  p_manual_nohold_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (man && live) |=> !hold);

  // R12: target lost during realignment forces holdover
  p_lost_target_r12: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!man && live && !busy_n && !(act_sel ? ref_ok[1] : ref_ok[0])) |=> (hold && busy_n));
endmodule

bind refsw_ctrl refsw_ctrl_chk #(.ALIGN_CYC(ALIGN_CYC)) u_chk (
  .clk     (clk),
  .rst_n_s (rst_n_s),
  .ref_ok  (ref_ok),
  .man     (man_w),
  .live    (live_w),
  .act_sel (act_sel),
  .busy_n  (busy_n),
  .hold    (hold)
);

// File: tb/refsw_ctrl_tb.sv
`timescale 1ns/1ps
module refsw_ctrl_tb;
  localparam int N = 8;

  logic       clk;
  logic       rst_n;
  logic [1:0] ref_ok;
  logic       usr_sel, mode_manual, bypass;
  logic       act_sel, busy_n, hold;

  typedef struct {
    logic  a;
    logic  b;
    logic  h;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   fin    = 0;

  refsw_ctrl #(.ALIGN_CYC(N)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_ok      (ref_ok),
    .usr_sel     (usr_sel),
    .mode_manual (mode_manual),
    .bypass      (bypass),
    .act_sel     (act_sel),
    .busy_n      (busy_n),
    .hold        (hold)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(input logic a, input logic b, input logic h, input string tag);
    exp_t e;
    e.a = a; e.b = b; e.h = h; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: drains the scoreboard just after each falling edge
  always @(negedge clk) begin
    #1;
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_run++;
      if (act_sel !== e.a || busy_n !== e.b || hold !== e.h) begin
        n_fail++;
        $display("FAIL %s: act_sel=%0b/%0b busy_n=%0b/%0b hold=%0b/%0b (actual/expected)",
                 e.tag, act_sel, e.a, busy_n, e.b, hold, e.h);
      end
    end
  end

  initial begin
    rst_n = 1'b0; usr_sel = 1'b1; ref_ok = 2'b11; mode_manual = 1'b0; bypass = 1'b0;
    tick(3);
    expect_out(0, 1, 0, "R10 values during reset");
    rst_n = 1'b1;
    tick(12);
    expect_out(1, 1, 0, "R1 select follows pin after reset");

    usr_sel = 1'b0; tick(3);
    expect_out(0, 0, 0, "R4 user edge switch");
    tick(N - 1);
    expect_out(0, 0, 0, "R6 busy still low at last window cycle");
    tick(1);
    expect_out(0, 1, 0, "R6 busy high after window");

    usr_sel = 1'b1; tick(1); usr_sel = 1'b0; tick(6);
    expect_out(0, 1, 0, "R5 one-cycle pulse ignored");

    ref_ok = 2'b10; tick(1);
    expect_out(1, 0, 0, "R2 automatic switch to qualified alternate");
    tick(N + 2);
    ref_ok = 2'b11; tick(4);
    expect_out(1, 1, 0, "R3 stays after former reference recovers");

    ref_ok = 2'b10; usr_sel = 1'b1; tick(5);
    expect_out(1, 1, 0, "R4 request equal to active ignored");
    usr_sel = 1'b0; tick(5);
    expect_out(1, 1, 0, "R4 request to unqualified target ignored");

    ref_ok = 2'b00; tick(1);
    expect_out(0, 1, 1, "R7 holdover entry");
    tick(5);
    expect_out(0, 1, 1, "R7 holdover held");

    ref_ok = 2'b11; tick(1);
    expect_out(0, 0, 0, "R8 both qualify takes user select, R11 busy low");
    tick(N + 2);
    expect_out(0, 1, 0, "R11 realignment complete");

    ref_ok = 2'b00; tick(1);
    expect_out(0, 1, 1, "R7 holdover again");
    ref_ok = 2'b10; tick(1);
    expect_out(1, 0, 0, "R8 single qualified reference taken");
    ref_ok = 2'b01; tick(1);
    expect_out(0, 1, 1, "R12 target lost while busy");
    tick(1);
    expect_out(0, 0, 0, "R8 exit to surviving reference");
    tick(N + 2);
    expect_out(0, 1, 0, "R6 window closes");

    mode_manual = 1'b1; ref_ok = 2'b00; tick(5);
    expect_out(0, 1, 0, "R9 manual never holds");
    usr_sel = 1'b1; tick(3);
    expect_out(1, 0, 0, "R9 manual follows pin despite flags");
    tick(N + 2);
    mode_manual = 1'b0; bypass = 1'b1; usr_sel = 1'b0; tick(3);
    expect_out(0, 0, 0, "R9 bypass follows pin");
    tick(N + 2);
    expect_out(0, 1, 0, "R9 bypass no holdover");
    bypass = 1'b0; tick(1);
    expect_out(0, 1, 1, "R7 automatic again with no reference");

    tick(2);
    fin = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule